// File: doc/BRIEF.md
# Expansion Bus Chip-Select Decoder

This block sits between a host bus and a simple ISA-style expansion bus. It looks at each host cycle, given as an address and four active-low strobes (memory read, memory write, I/O read, I/O write). From these it produces active-low chip selects for a boot ROM, for one programmable memory window and for two programmable I/O ranges. The window select is also split by direction into a window read strobe and a window write strobe. The four host strobes are merged into one read strobe and one write strobe.

For the device that claims a cycle, the decoder reports two attributes taken from configuration bits: the data-bus width (8 or 16 bits) and whether the cycle may finish with zero wait states. A cycle that no select claims can be passed on through subtractive decode. Software can switch that off for I/O cycles, for memory cycles, or for both. Every output is registered, so each output reflects the inputs that were sampled at the previous rising clock edge.

Top module: `xbus_csel`

## Requirements
- R1: `rom_cs_n` goes low for a memory cycle when address bits [31:24] are all ones and `(addr[23:16] & cfg_rom_mask) == cfg_rom_mask`. A mask of zero therefore covers the full top 16 MB.
- R2: `win_cs_n` goes low for a memory cycle when `cfg_win_en` is 1 and `(addr & cfg_win_mask) == (cfg_win_base & cfg_win_mask)`. The window size is a power of two and the base is aligned to that size.
- R3: `io_cs_n[k]` goes low for an I/O cycle when `cfg_io_en[k]` is 1 and `(addr[15:0] & mask_k) == (base_k & mask_k)`. Range k occupies bits [16k+15:16k] of `cfg_io_base` and `cfg_io_mask`.
- R4: `win_rd_n` is low only when the window is selected and memory read is active. `win_wr_n` is low only when the window is selected and memory write is active.
- R5: `rd_n` is low when I/O read or memory read is active. `wr_n` is low when I/O write or memory write is active.
- R6: While the ROM or the window is selected, `bus_w16` equals that device's width bit and `zws` equals its zero-wait bit, at either width.
- R7: While I/O range k is selected, `bus_w16` equals `cfg_io_w16[k]`. `zws` is 1 only when `cfg_io_zws[k]` is 1 and `cfg_io_w16[k]` is 0.
- R8: A cycle that no select claims, and an idle cycle, give `bus_w16` = 0 and `zws` = 0.
- R9: At most one chip select is low at any time. The priority order is ROM, then window, then I/O range 0, then I/O range 1.
- R10: `sub_fwd` is 1 for an unclaimed memory cycle unless `cfg_nofwd_mem` is 1, and for an unclaimed I/O cycle unless `cfg_nofwd_io` is 1. It is 0 when the cycle is claimed or the bus is idle.
- R11: All outputs are registered with one cycle of latency. While `rst_n` is low, every select and strobe is high and `bus_w16`, `zws` and `sub_fwd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (32) | Cycle address; I/O cycles use the low IOAW bits |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| cfg_rom_mask | input | RMW (8) | Narrows the ROM region inside the top 16 MB |
| cfg_rom_w16 | input | 1 | ROM bus width: 1 = 16 bits |
| cfg_rom_zws | input | 1 | ROM zero-wait enable |
| cfg_win_en | input | 1 | Memory window enable |
| cfg_win_base | input | AW | Memory window base |
| cfg_win_mask | input | AW | Memory window compare mask |
| cfg_win_w16 | input | 1 | Window bus width: 1 = 16 bits |
| cfg_win_zws | input | 1 | Window zero-wait enable |
| cfg_io_en | input | N_IO (2) | Per-range I/O enable |
| cfg_io_base | input | N_IO*IOAW | Packed I/O range bases |
| cfg_io_mask | input | N_IO*IOAW | Packed I/O range masks |
| cfg_io_w16 | input | N_IO | Per-range width: 1 = 16 bits |
| cfg_io_zws | input | N_IO | Per-range zero-wait request |
| cfg_nofwd_io | input | 1 | Disables forwarding of unclaimed I/O cycles |
| cfg_nofwd_mem | input | 1 | Disables forwarding of unclaimed memory cycles |
| rom_cs_n | output | 1 | Boot ROM select |
| win_cs_n | output | 1 | Memory window select |
| io_cs_n | output | N_IO | I/O range selects |
| win_rd_n | output | 1 | Window read strobe |
| win_wr_n | output | 1 | Window write strobe |
| rd_n | output | 1 | Merged read strobe |
| wr_n | output | 1 | Merged write strobe |
| bus_w16 | output | 1 | Claimed device is 16 bits wide |
| zws | output | 1 | Cycle may finish with zero wait states |
| sub_fwd | output | 1 | Unclaimed cycle is forwarded by subtractive decode |

## Verification
Some properties hold on every cycle and are checked by assertions. These are: at most one select is low, the window strobes imply both the window select and the matching merged strobe, a 16-bit I/O device never gets zero wait, an unclaimed cycle reports 8 bits with no zero wait, forwarding never happens together with a select, and the merged strobes follow the host strobes one cycle later. Other behaviour depends on configuration and can only be shown by the bench's scenarios. That covers which address actually hits which decoder, how the ROM mask narrows the region, the priority when the ROM and the window overlap, turning off an I/O range, and each of the forwarding-disable settings.

// File: rtl/xbus_pkg.sv
// Shared types for the expansion bus chip-select decoder.
// Assumes: the attribute pair travels together from the arbiter to the output registers.
package xbus_pkg;

    // Data width and wait attribute of the device that claims a cycle
    typedef struct packed {
        logic w16;
        logic zws;
    } xbus_attr_t;

    localparam xbus_attr_t XBUS_ATTR_NONE = '{w16: 1'b0, zws: 1'b0};

endpackage

// File: rtl/xbus_match.sv
// Masked address comparator for one programmable range.
// Assumes: the mask has ones on the bits that must equal the base; the range size is
// a power of two and the base is aligned to it, so one equality test suffices.
module xbus_match #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mask,
    output logic         hit
);

    // Compare only the masked bits of address and base
    always_comb begin
        hit = en && ((addr & mask) == (base & mask));
    end

endmodule

// File: rtl/xbus_prio.sv
// Fixed-priority arbiter and attribute selector for the decoder hits.
// Assumes: priority ROM > window > I/O range 0 > ... > I/O range N_IO-1, and an I/O
// device gets zero wait only when it is configured 8 bits wide.
module xbus_prio
    import xbus_pkg::*;
#(
    parameter int N_IO = 2
) (
    input  logic            rom_hit,
    input  logic            win_hit,
    input  logic [N_IO-1:0] io_hit,
    input  logic            rom_w16,
    input  logic            rom_zws,
    input  logic            win_w16,
    input  logic            win_zws,
    input  logic [N_IO-1:0] io_w16,
    input  logic [N_IO-1:0] io_zws,
    output logic            rom_gnt,
    output logic            win_gnt,
    output logic [N_IO-1:0] io_gnt,
    output logic            any_gnt,
    output xbus_attr_t      attr
);

    logic [N_IO:0] blocked;

    // Memory selects outrank every I/O range
    always_comb begin
        rom_gnt    = rom_hit;
        win_gnt    = win_hit && !rom_hit;
        blocked[0] = rom_hit || win_hit;
    end

    // Each I/O range loses to every higher-priority hit
    for (genvar k = 0; k < N_IO; k++) begin : g_io
        always_comb begin
            io_gnt[k]    = io_hit[k] && !blocked[k];
            blocked[k+1] = blocked[k] || io_hit[k];
        end
    end

    // Flag that some select claims the cycle
    always_comb begin
        any_gnt = blocked[N_IO];
    end

    // Pick the width and wait attribute of the granted device
    always_comb begin
        attr = XBUS_ATTR_NONE;
        if (rom_gnt) begin
            attr.w16 = rom_w16;
            attr.zws = rom_zws;
        end else if (win_gnt) begin
            attr.w16 = win_w16;
            attr.zws = win_zws;
        end else begin
            for (int k = 0; k < N_IO; k++) begin
                if (io_gnt[k]) begin
                    attr.w16 = io_w16[k];
                    attr.zws = io_zws[k] && !io_w16[k];
                end
            end
        end
    end

endmodule

// File: rtl/xbus_csel.sv
// Chip-select decoder for an ISA-style expansion bus.
// Decodes each host cycle into ROM, window and I/O-range selects, merges the strobes,
// reports width and zero-wait attributes and decides subtractive forwarding.
// Assumes: strobes are active low and memory and I/O strobes are not active at the
// same time; configuration inputs are stable around the clock edge; all outputs are
// registered, with a synchronous active-low reset.
module xbus_csel
    import xbus_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IOAW = 16,
    parameter int N_IO = 2,
    parameter int RMW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 memr_n,
    input  logic                 memw_n,
    input  logic                 ior_n,
    input  logic                 iow_n,
    input  logic [RMW-1:0]       cfg_rom_mask,
    input  logic                 cfg_rom_w16,
    input  logic                 cfg_rom_zws,
    input  logic                 cfg_win_en,
    input  logic [AW-1:0]        cfg_win_base,
    input  logic [AW-1:0]        cfg_win_mask,
    input  logic                 cfg_win_w16,
    input  logic                 cfg_win_zws,
    input  logic [N_IO-1:0]      cfg_io_en,
    input  logic [N_IO*IOAW-1:0] cfg_io_base,
    input  logic [N_IO*IOAW-1:0] cfg_io_mask,
    input  logic [N_IO-1:0]      cfg_io_w16,
    input  logic [N_IO-1:0]      cfg_io_zws,
    input  logic                 cfg_nofwd_io,
    input  logic                 cfg_nofwd_mem,
    output logic                 rom_cs_n,
    output logic                 win_cs_n,
    output logic [N_IO-1:0]      io_cs_n,
    output logic                 win_rd_n,
    output logic                 win_wr_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 bus_w16,
    output logic                 zws,
    output logic                 sub_fwd
);

    localparam int TOPW    = 8;
    localparam int ROM_MSB = AW - TOPW - 1;
    localparam int ROM_LSB = ROM_MSB - RMW + 1;

    logic            mem_cyc, io_cyc;
    logic            rom_hit, win_hit;
    logic [N_IO-1:0] io_hit, io_gnt;
    logic            rom_gnt, win_gnt, any_gnt;
    logic            fwd_d;
    xbus_attr_t      attr;

    // Classify the current cycle from the strobes
    always_comb begin
        mem_cyc = !memr_n || !memw_n;
        io_cyc  = !ior_n || !iow_n;
    end

    // Boot ROM: top 16 MB, narrowed by the mask bits just below the top byte
    always_comb begin
        rom_hit = mem_cyc && (&addr[AW-1:AW-TOPW])
                  && ((addr[ROM_MSB:ROM_LSB] & cfg_rom_mask) == cfg_rom_mask);
    end

    logic win_match;
    xbus_match #(.W(AW)) i_win_match (
        .en   (cfg_win_en),
        .addr (addr),
        .base (cfg_win_base),
        .mask (cfg_win_mask),
        .hit  (win_match)
    );

    // Window responds only to memory cycles
    always_comb begin
        win_hit = mem_cyc && win_match;
    end

    // One comparator per I/O range, qualified by I/O cycles
    for (genvar k = 0; k < N_IO; k++) begin : g_iorng
        logic io_match;
        xbus_match #(.W(IOAW)) i_io_match (
            .en   (cfg_io_en[k]),
            .addr (addr[IOAW-1:0]),
            .base (cfg_io_base[k*IOAW +: IOAW]),
            .mask (cfg_io_mask[k*IOAW +: IOAW]),
            .hit  (io_match)
        );
        always_comb begin
            io_hit[k] = io_cyc && io_match;
        end
    end

    xbus_prio #(.N_IO(N_IO)) i_prio (
        .rom_hit (rom_hit),
        .win_hit (win_hit),
        .io_hit  (io_hit),
        .rom_w16 (cfg_rom_w16),
        .rom_zws (cfg_rom_zws),
        .win_w16 (cfg_win_w16),
        .win_zws (cfg_win_zws),
        .io_w16  (cfg_io_w16),
        .io_zws  (cfg_io_zws),
        .rom_gnt (rom_gnt),
        .win_gnt (win_gnt),
        .io_gnt  (io_gnt),
        .any_gnt (any_gnt),
        .attr    (attr)
    );

    // Forward an unclaimed cycle unless its type has forwarding disabled
    always_comb begin
        fwd_d = !any_gnt && ((mem_cyc && !cfg_nofwd_mem) || (io_cyc && !cfg_nofwd_io));
    end

    // Register every select, strobe and attribute so the outputs are glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_cs_n <= 1'b1;
            win_cs_n <= 1'b1;
            io_cs_n  <= '1;
            win_rd_n <= 1'b1;
            win_wr_n <= 1'b1;
            rd_n     <= 1'b1;
            wr_n     <= 1'b1;
            bus_w16  <= 1'b0;
            zws      <= 1'b0;
            sub_fwd  <= 1'b0;
        end else begin
            rom_cs_n <= !rom_gnt;
            win_cs_n <= !win_gnt;
            io_cs_n  <= ~io_gnt;
            win_rd_n <= !(win_gnt && !memr_n);
            win_wr_n <= !(win_gnt && !memw_n);
            rd_n     <= ior_n && memr_n;
            wr_n     <= iow_n && memw_n;
            bus_w16  <= attr.w16;
            zws      <= attr.zws;
            sub_fwd  <= fwd_d;
        end
    end

endmodule

// File: rtl/xbus_csel_chk.sv
// Property checker for xbus_csel, attached with bind.
// Assumes: a synchronous active-low reset; the strobe properties look one cycle back
// only after a cycle out of reset.
module xbus_csel_chk #(
    parameter int N_IO = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            memr_n,
    input logic            memw_n,
    input logic            ior_n,
    input logic            iow_n,
    input logic            rom_cs_n,
    input logic            win_cs_n,
    input logic [N_IO-1:0] io_cs_n,
    input logic            win_rd_n,
    input logic            win_wr_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            bus_w16,
    input logic            zws,
    input logic            sub_fwd
);

    logic mem_sel, none_sel;

    // Summaries of the select outputs used by several properties
    always_comb begin
        mem_sel  = !rom_cs_n || !win_cs_n;
        none_sel = rom_cs_n && win_cs_n && (&io_cs_n);
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rom_cs_n, ~win_cs_n, ~io_cs_n}) <= 1);                          // R9

    AST_WIN_RD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !win_rd_n |-> (!win_cs_n && !rd_n));                                          // R4

    AST_WIN_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr_n |-> (!win_cs_n && !wr_n));                                          // R4

    AST_IO16_NO_ZWS: assert property (@(posedge clk) disable iff (!rst_n)
        (zws && bus_w16) |-> mem_sel);                                                // R7

    AST_UNCLAIMED_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        none_sel |-> (!bus_w16 && !zws));                                             // R8

    AST_FWD_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        sub_fwd |-> none_sel);                                                        // R10

    AST_RD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_n == $past(ior_n && memr_n)));                           // R5

    AST_WR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_n == $past(iow_n && memw_n)));                           // R5

endmodule

bind xbus_csel xbus_csel_chk #(.N_IO(N_IO)) i_xbus_csel_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .rom_cs_n (rom_cs_n),
    .win_cs_n (win_cs_n),
    .io_cs_n  (io_cs_n),
    .win_rd_n (win_rd_n),
    .win_wr_n (win_wr_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bus_w16  (bus_w16),
    .zws      (zws),
    .sub_fwd  (sub_fwd)
);

// File: tb/test_xbus_csel.sv
// Scoreboard bench for xbus_csel: the driver pushes expected output words, and the
// monitor pops and compares them one cycle later, just after the rising edge.
module test_xbus_csel;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, IOAW = 16, N_IO = 2, RMW = 8;
    localparam logic [3:0] MR = 4'b0111, MW = 4'b1011, IR = 4'b1101, IW = 4'b1110,
                           IDLE = 4'b1111;   // {memr_n, memw_n, ior_n, iow_n}

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic memr_n = 1'b1, memw_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
    logic [RMW-1:0] cfg_rom_mask = '0;
    logic cfg_rom_w16 = 1'b1, cfg_rom_zws = 1'b0;
    logic cfg_win_en = 1'b1;
    logic [AW-1:0] cfg_win_base = 32'h000D_0000, cfg_win_mask = 32'hFFFF_8000;
    logic cfg_win_w16 = 1'b0, cfg_win_zws = 1'b1;
    logic [N_IO-1:0] cfg_io_en = 2'b11;
    logic [N_IO*IOAW-1:0] cfg_io_base = {16'h0310, 16'h0300};
    logic [N_IO*IOAW-1:0] cfg_io_mask = {16'hFFF8, 16'hFFF0};
    logic [N_IO-1:0] cfg_io_w16 = 2'b10, cfg_io_zws = 2'b11;
    logic cfg_nofwd_io = 1'b0, cfg_nofwd_mem = 1'b0;
    logic rom_cs_n, win_cs_n, win_rd_n, win_wr_n, rd_n, wr_n, bus_w16, zws, sub_fwd;
    logic [N_IO-1:0] io_cs_n;

    int checks = 0, fails = 0;
    logic [10:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_csel #(.AW(AW), .IOAW(IOAW), .N_IO(N_IO), .RMW(RMW)) i_xbus_csel (.*);

    // Output word: {rom, win, io1, io0, win_rd, win_wr, rd, wr, w16, zws, fwd}
    function automatic logic [10:0] actual();
        return {rom_cs_n, win_cs_n, io_cs_n[1], io_cs_n[0], win_rd_n, win_wr_n,
                rd_n, wr_n, bus_w16, zws, sub_fwd};
    endfunction

    // Expected output word derived from the requirements
    function automatic logic [10:0] model(input logic [AW-1:0] a, input logic [3:0] s);
        logic is_mem, is_io, r, w, claimed, w16, z, f;
        logic [1:0] io;
        logic [IOAW-1:0] b, m;
        logic [3:0] sel;    // one-hot {io1, io0, win, rom} after priority
        is_mem = !s[3] || !s[2];
        is_io  = !s[1] || !s[0];
        r = is_mem && a[31:24] == 8'hFF && ((a[23:16] & cfg_rom_mask) == cfg_rom_mask);
        w = is_mem && cfg_win_en && (((a ^ cfg_win_base) & cfg_win_mask) == '0);
        for (int k = 0; k < 2; k++) begin
            b = cfg_io_base[k*16 +: 16];
            m = cfg_io_mask[k*16 +: 16];
            io[k] = is_io && cfg_io_en[k] && (((a[15:0] ^ b) & m) == '0);
        end
        if (r)          sel = 4'b0001;
        else if (w)     sel = 4'b0010;
        else if (io[0]) sel = 4'b0100;
        else if (io[1]) sel = 4'b1000;
        else            sel = 4'b0000;
        claimed = |sel;
        w16 = 1'b0; z = 1'b0;
        if (sel[0])      begin w16 = cfg_rom_w16;   z = cfg_rom_zws; end
        else if (sel[1]) begin w16 = cfg_win_w16;   z = cfg_win_zws; end
        else if (sel[2]) begin w16 = cfg_io_w16[0]; z = cfg_io_zws[0] && !cfg_io_w16[0]; end
        else if (sel[3]) begin w16 = cfg_io_w16[1]; z = cfg_io_zws[1] && !cfg_io_w16[1]; end
        f = !claimed && ((is_mem && !cfg_nofwd_mem) || (is_io && !cfg_nofwd_io));
        return {~sel[0], ~sel[1], ~sel[3], ~sel[2],
                !(sel[1] && !s[3]), !(sel[1] && !s[2]),
                s[3] && s[1], s[2] && s[0], w16, z, f};
    endfunction

    // Driver: apply one cycle at the falling edge and queue its expected result
    task automatic apply(input logic [AW-1:0] a, input logic [3:0] s, input string tag);
        @(negedge clk);
        addr = a;
        {memr_n, memw_n, ior_n, iow_n} = s;
        exp_q.push_back(model(a, s));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after the edge that registers the queued cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [10:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (actual() !== e) begin
                fails++;
                $display("FAIL %s: actual %b expected %b", t, actual(), e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        {memr_n, ior_n} = 2'b00;
        @(negedge clk);
        checks++;
        if (actual() !== 11'b1111_1111_000) begin
            fails++;
            $display("FAIL R11: actual %b expected %b", actual(), 11'b1111_1111_000);
        end
        {memr_n, ior_n} = 2'b11;
        rst_n = 1'b1;

        apply(32'hFFFF_FFF0, MR, "R1 rom hit, R6 w16");
        apply(32'h00FF_0000, MR, "R8 R10 unclaimed memory");
        apply(32'h000D_1234, MR, "R2 R4 window read, R6 zws at 8-bit");
        apply(32'h000D_7FFF, MW, "R4 R5 window write top byte");
        apply(32'h000D_8000, MW, "R2 just past window");
        apply(32'h0000_0305, IR, "R3 R7 io0 8-bit zws");
        apply(32'h0000_0312, IW, "R7 io1 16-bit drops zws");
        apply(32'h0000_0318, IR, "R8 R10 unclaimed io");
        apply(32'h0000_0000, IDLE, "R8 R10 idle bus");

        @(negedge clk); cfg_rom_mask = 8'hF0;
        apply(32'hFF00_0000, MR, "R1 mask narrows rom");
        apply(32'hFFF0_0000, MW, "R1 inside narrowed rom");

        @(negedge clk); cfg_win_base = 32'hFF00_0000; cfg_win_mask = 32'hFFFF_0000;
        cfg_rom_mask = 8'h00;
        apply(32'hFF00_0010, MR, "R9 rom beats window");
        @(negedge clk); cfg_rom_mask = 8'hF0;
        apply(32'hFF00_1000, MR, "R9 window when rom masked out");

        @(negedge clk); cfg_rom_mask = 8'h00; cfg_rom_zws = 1'b1;
        apply(32'hFFAB_0000, MW, "R6 rom zws at 16-bit");

        @(negedge clk); cfg_nofwd_io = 1'b1;
        apply(32'h0000_0400, IR, "R10 io forwarding off");
        apply(32'h1234_0000, MR, "R10 memory still forwarded");
        @(negedge clk); cfg_nofwd_mem = 1'b1;
        apply(32'h1234_0000, MW, "R10 all forwarding off");

        @(negedge clk); cfg_io_en = 2'b10;
        apply(32'h0000_0305, IW, "R3 disabled io0 ignores hit");
        apply(32'h0000_0311, IR, "R3 io1 still enabled");

        @(negedge clk); cfg_io_w16 = 2'b00;
        apply(32'h0000_0317, IW, "R7 io1 at 8-bit gets zws");

        apply(32'h0000_0000, IDLE, "R11 return to idle");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule